// File: doc/BRIEF.md
# NUMA Page Migration Detector

This block keeps the per-node affinity statistics of one memory page up to date and decides when that page should move to a different NUMA node. Every page owns a vector of small saturating counters, one for each node, held in external storage. When a statistics event arrives from a core on some node, the block receives that page's counter vector on a read port. If the event is marked as qualifying, meaning it passed the upstream access-count filter, the block raises the source node's counter and lowers every other node's counter. It returns the new vector on a write port in the same cycle.

From the updated vector it then compares the source node's counter with the counter of the node that currently holds the page. If the source node leads by at least a global programmable threshold, the block issues a migration request that names the page and the source node. Software takes this request over a valid/ready interface and decides whether to move the page. The block holds one request at a time. A request that arrives while the previous one is still waiting is discarded and counted in a saturating drop counter. A larger threshold adds hysteresis, so the block issues fewer requests.

Top module: `numa_migrate_detector`

## Requirements
- R1: After reset, `req_valid` is 0 and `drop_count` is 0.
- R2: An event with `ev_valid` or `ev_qual` low does not assert `cnt_wr_en` and causes no request.
- R3: On a qualifying event, `cnt_wr_en` is 1 in the same cycle. In `cnt_wr`, the field of node `ev_node` is its `cnt_rd` value plus one and every other field is its `cnt_rd` value minus one. Node i's counter occupies bits [i*CNT_W +: CNT_W] of both vectors.
- R4: Counters saturate. A field at its maximum (all ones) that is incremented stays at the maximum, and a field at 0 that is decremented stays at 0.
- R5: A qualifying event with `ev_home` different from `ev_node`, whose updated vector gives counter[ev_node] − counter[ev_home] ≥ `mig_thresh`, presents a request one clock later: `req_valid` is 1, `req_page` is `ev_page` and `req_node` is `ev_node`.
- R6: A qualifying event with `ev_home` equal to `ev_node` never produces a request.
- R7: When the counter difference is smaller than `mig_thresh`, no request is produced. For the same counters, raising the threshold above the difference suppresses a request that a lower threshold would produce.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_page` and `req_node` stay unchanged. A request is consumed on a cycle with both high.
- R9: A new request that arises while a request is pending and not being accepted is discarded, and `drop_count` increases by one, saturating at its maximum. A new request that arises in the same cycle the pending one is accepted replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mig_thresh | input | CNT_W | Global migration threshold (control register value) |
| ev_valid | input | 1 | Statistics event present |
| ev_qual | input | 1 | Event passed the access-count filter |
| ev_node | input | $clog2(NODES) | Node of the core that raised the event |
| ev_home | input | $clog2(NODES) | Node currently holding the page |
| ev_page | input | PAGE_W | Physical page number of the event |
| cnt_rd | input | NODES*CNT_W | Counter vector read for the page |
| cnt_wr_en | output | 1 | Write enable for the updated vector |
| cnt_wr | output | NODES*CNT_W | Updated counter vector |
| req_valid | output | 1 | Migration request pending |
| req_ready | input | 1 | Software accepts the request |
| req_page | output | PAGE_W | Page to migrate |
| req_node | output | $clog2(NODES) | Destination node |
| drop_count | output | DROP_W | Saturating count of discarded requests |

## Verification
The counter update is purely combinational. A wrong increment, decrement or saturation rule shows on `cnt_wr` in the event's own cycle, and the bench compares every field there, including fields at 0 and at the maximum. A wrong comparison, such as using the old vector or an off-by-one threshold, shows one clock later as a missing or spurious `req_valid`. The bench therefore checks cases where the difference equals the threshold exactly and where it is one below. Faults in the single request slot show as a changed `req_page` while software stalls, or as a `drop_count` that does not advance or that wraps.

// File: rtl/numa_migrate_detector.sv
module numa_migrate_detector #(
  parameter int NODES  = 4,
  parameter int CNT_W  = 4,
  parameter int PAGE_W = 20,
  parameter int DROP_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CNT_W-1:0]             mig_thresh,
  input  logic                         ev_valid,
  input  logic                         ev_qual,
  input  logic [$clog2(NODES)-1:0]     ev_node,
  input  logic [$clog2(NODES)-1:0]     ev_home,
  input  logic [PAGE_W-1:0]            ev_page,
  input  logic [NODES*CNT_W-1:0]       cnt_rd,
  output logic                         cnt_wr_en,
  output logic [NODES*CNT_W-1:0]       cnt_wr,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [PAGE_W-1:0]            req_page,
  output logic [$clog2(NODES)-1:0]     req_node,
  output logic [DROP_W-1:0]            drop_count
);
  localparam int NW = $clog2(NODES);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [DROP_W-1:0] DMAX = {DROP_W{1'b1}};

  logic             fire_ev;
  logic [CNT_W-1:0] own_c, home_c;
  logic             lead_ok, want_req, slot_free;

  assign fire_ev   = ev_valid && ev_qual;
  assign cnt_wr_en = fire_ev;

  for (genvar i = 0; i < NODES; i++) begin : g_cnt
    logic [CNT_W-1:0] old_c;
    assign old_c = cnt_rd[i*CNT_W +: CNT_W];
    assign cnt_wr[i*CNT_W +: CNT_W] =
      (ev_node == NW'(i)) ? ((old_c == CMAX) ? CMAX : old_c + 1'b1)
                          : ((old_c == '0)   ? '0   : old_c - 1'b1);

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |-> ((ev_node == NW'(i)) ? (cnt_wr[i*CNT_W +: CNT_W] >= old_c)
                                          : (cnt_wr[i*CNT_W +: CNT_W] <= old_c)));
  end

  assign own_c     = cnt_wr[ev_node*CNT_W +: CNT_W];
  assign home_c    = cnt_wr[ev_home*CNT_W +: CNT_W];
  assign lead_ok   = {1'b0, own_c} >= ({1'b0, home_c} + {1'b0, mig_thresh});
  assign want_req  = fire_ev && (ev_node != ev_home) && lead_ok;
  assign slot_free = !req_valid || req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_page   <= '0;
      req_node   <= '0;
      drop_count <= '0;
    end else begin
      if (want_req && slot_free) begin
        req_valid <= 1'b1;
        req_page  <= ev_page;
        req_node  <= ev_node;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (want_req && !slot_free && drop_count != DMAX)
        drop_count <= drop_count + 1'b1;
    end
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_qual) |-> !cnt_wr_en);

  p_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_ev && ev_home == ev_node && (!req_valid || req_ready)) |=> !req_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_page) && $stable(req_node)));

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && want_req && drop_count != DMAX)
      |=> drop_count == $past(drop_count) + 1'b1);

  p_drop_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == DMAX) |=> drop_count == DMAX);
endmodule

// File: tb/sim_numa_migrate_detector.sv
`timescale 1ns/1ps
module sim_numa_migrate_detector;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  mig_thresh = 0;
  logic        ev_valid = 0, ev_qual = 0;
  logic [1:0]  ev_node = 0, ev_home = 0;
  logic [19:0] ev_page = 0;
  logic [15:0] cnt_rd = 0;
  logic        cnt_wr_en;
  logic [15:0] cnt_wr;
  logic        req_valid;
  logic        req_ready = 1;
  logic [19:0] req_page;
  logic [1:0]  req_node;
  logic [7:0]  drop_count;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  numa_migrate_detector u0 (.*);

  // {home, node, thresh, rd, expected wr, expected request}
  localparam logic [40:0] TV [11] = '{
    {2'd0, 2'd1, 4'd2,  16'h0000, 16'h0010, 1'b0},
    {2'd0, 2'd1, 4'd1,  16'h0010, 16'h0020, 1'b1},
    {2'd2, 2'd2, 4'd0,  16'h0300, 16'h0400, 1'b0},
    {2'd0, 2'd3, 4'd5,  16'h5321, 16'h6210, 1'b1},
    {2'd0, 2'd3, 4'd7,  16'h5321, 16'h6210, 1'b0},
    {2'd1, 2'd0, 4'd15, 16'hF00F, 16'hE00F, 1'b1},
    {2'd3, 2'd0, 4'd1,  16'hF00F, 16'hE00F, 1'b1},
    {2'd3, 2'd0, 4'd2,  16'hF00F, 16'hE00F, 1'b0},
    {2'd1, 2'd2, 4'd0,  16'h0000, 16'h0100, 1'b1},
    {2'd2, 2'd1, 4'd3,  16'h8888, 16'h7797, 1'b0},
    {2'd2, 2'd1, 4'd2,  16'h8888, 16'h7797, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] home, input logic [1:0] node, input logic [19:0] page,
                      input logic [15:0] rd);
    ev_valid = 1; ev_qual = 1; ev_home = home; ev_node = node; ev_page = page; cnt_rd = rd;
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(drop_count == 0, "R1 drop_count", drop_count, 0);

    for (int i = 0; i < 11; i++) begin
      mig_thresh = TV[i][36:33];
      fire(TV[i][40:39], TV[i][38:37], 20'h100 + i, TV[i][32:17]);
      #1;
      chk(cnt_wr_en == 1, "R3 write enable", cnt_wr_en, 1);
      chk(cnt_wr == TV[i][16:1], "R3/R4 counter update", cnt_wr, TV[i][16:1]);
      @(negedge clk);
      ev_valid = 0;
      chk(req_valid == TV[i][0], "R5/R6/R7 request", req_valid, TV[i][0]);
      if (TV[i][0]) begin
        chk(req_page == 20'h100 + i, "R5 page", req_page, 20'h100 + i);
        chk(req_node == TV[i][38:37], "R5 node", req_node, TV[i][38:37]);
      end
      @(negedge clk);
    end

    // R2: unqualified and invalid events
    mig_thresh = 0;
    fire(2'd0, 2'd1, 20'h200, 16'h0000);
    ev_qual = 0; #1;
    chk(cnt_wr_en == 0, "R2 unqualified write", cnt_wr_en, 0);
    @(negedge clk);
    chk(req_valid == 0, "R2 unqualified request", req_valid, 0);
    ev_qual = 1; ev_valid = 0; #1;
    chk(cnt_wr_en == 0, "R2 invalid write", cnt_wr_en, 0);
    @(negedge clk);
    chk(req_valid == 0, "R2 invalid request", req_valid, 0);

    // R8/R9: hold while stalled, drop, replace on accept
    req_ready = 0;
    fire(2'd0, 2'd1, 20'hA1, 16'h0000);
    @(negedge clk);
    chk(req_valid && req_page == 20'hA1, "R8 first request", req_page, 20'hA1);
    fire(2'd0, 2'd2, 20'hB2, 16'h0000);
    @(negedge clk);
    ev_valid = 0;
    chk(drop_count == 1, "R9 drop counted", drop_count, 1);
    chk(req_page == 20'hA1 && req_node == 1, "R8 held page", req_page, 20'hA1);
    @(negedge clk);
    chk(req_valid && req_page == 20'hA1, "R8 still held", req_page, 20'hA1);
    req_ready = 1;
    fire(2'd1, 2'd3, 20'hC3, 16'h0000);
    @(negedge clk);
    ev_valid = 0;
    chk(req_valid && req_page == 20'hC3 && req_node == 3, "R9 replace on accept", req_page, 20'hC3);
    chk(drop_count == 1, "R9 no drop on accept", drop_count, 1);
    @(negedge clk);
    chk(req_valid == 0, "R8 consumed", req_valid, 0);

    // R9: drop counter saturation
    req_ready = 0;
    fire(2'd0, 2'd1, 20'hD4, 16'h0000);
    for (int k = 0; k < 300; k++) @(negedge clk);
    ev_valid = 0;
    chk(drop_count == 8'hFF, "R9 drop saturates", drop_count, 8'hFF);
    chk(req_page == 20'hD4, "R8 held through drops", req_page, 20'hD4);
    req_ready = 1;
    @(negedge clk);

    // R1: reset again clears state
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk(req_valid == 0 && drop_count == 0, "R1 re-reset", drop_count, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule